// File: doc/BRIEF.md
# Tri-Level Single-Pin Command Decoder

This block turns the state of one control pin into trim commands. The pin normally rests at a middle level, about half the logic supply, and that is also where it settles when nothing drives it. Three comparator flags report its level: one below the low threshold, one above the high threshold, and one above a higher programming threshold. A move from the middle level down to low and back asks for one increment. A move up to high and back asks for one decrement. Holding the pin above the programming threshold for long enough asks for the current trim value to be written to non-volatile storage.

The flags and the enable pin pass through a synchronizer before they are used. All pulse-width checks run on a cycle counter whose limits come from the clock frequency parameter. Short excursions are discarded. A minimum dwell at the middle level is needed between counts. The first qualified excursion after power-up is dropped, because the comparators may start in an unknown state. The three outputs are single-cycle strobes that drive the command inputs of the trim counter.

Top module: `tri_level_cmd_decoder`

## Requirements
- R1: While reset is asserted and on the first cycles after it, the increment, decrement and program strobes are all 0, and the first-excursion discard is re-armed.
- R2: A qualified excursion from mid to low (only the low flag set) gives exactly one increment strobe, issued after the pin returns to mid.
- R3: A qualified excursion from mid to high (high flag set, programming flag clear) gives exactly one decrement strobe, issued after the pin returns to mid.
- R4: An excursion qualifies only if it lasts at least QUAL_US microseconds of clock cycles (QUAL_US=100, which is 1000 cycles at a 10 MHz CLK_HZ). Shorter excursions, including those under 20 us, give no strobe. Any excursion of 200 us or more qualifies.
- R5: An excursion that starts after fewer than GAP_US microseconds (10 us, 100 cycles at 10 MHz) at mid, counted from the last return to mid or from reset, gives no strobe.
- R6: After reset, the first excursion that would otherwise produce an increment or decrement while enabled is dropped. Rejected excursions and program holds do not use up this discard.
- R7: Holding the programming flag for more than PROG_US microseconds (200 us, more than 2000 cycles at 10 MHz) issues exactly one program-request strobe. A hold of exactly 2000 cycles issues none.
- R8: An excursion that reaches the programming level never produces a decrement strobe, whether or not the hold was long enough.
- R9: While the enable input is low, no strobe of any kind is issued.
- R10: An excursion that reverses from low to high, or from high to low, without passing through mid gives no strobe.
- R11: Each strobe is one cycle wide, and no two strobes are active in the same cycle.
- R12: Flag priority is programming over high over low. With none of the flags set, the pin is at mid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, standing in for power-up |
| en_i | input | 1 | Asynchronous enable for adjustment and programming |
| below_lo_i | input | 1 | Comparator flag: pin below the low threshold |
| above_hi_i | input | 1 | Comparator flag: pin above the high threshold |
| above_prog_i | input | 1 | Comparator flag: pin above the programming threshold |
| inc_o | output | 1 | One-cycle increment command |
| dec_o | output | 1 | One-cycle decrement command |
| prog_req_o | output | 1 | One-cycle program-request command |

## Verification
The bench probes the width limit one cycle either side of the acceptance threshold. A design with an off-by-one error there would count a 999-cycle excursion or drop a 1000-cycle one. The mid-dwell limit is probed at 99 and 100 cycles in the same way. The program hold is driven at 2000 and 2001 cycles. A comparator that fires one cycle early shows up as a stray request, and one that fires late as a missing request; if the request is not latched out, a decrement appears as well.

The bench leads with a rejected short excursion before the first qualified one. It also asserts reset a second time. Together these catch a discard flag that is cleared by the wrong event or never re-armed. Reversed excursions and disabled holds confirm that the block stays silent where a careless design would issue a count.

// File: rtl/tlcd_pkg.sv
`timescale 1ns/1ps
package tlcd_pkg;

  typedef enum logic [1:0] {
    LV_MID  = 2'd0,
    LV_LOW  = 2'd1,
    LV_HIGH = 2'd2,
    LV_PROG = 2'd3
  } level_t;

  // microseconds to clock cycles, kept in integer arithmetic
  function automatic int unsigned us_to_cycles(input int unsigned clk_hz,
                                               input int unsigned us);
    return ((clk_hz / 1000) * us) / 1000;
  endfunction

  // programming flag wins over high, high wins over low
  function automatic level_t pick_level(input logic lo, input logic hi,
                                        input logic pr);
    if (pr)      return LV_PROG;
    else if (hi) return LV_HIGH;
    else if (lo) return LV_LOW;
    else         return LV_MID;
  endfunction

  function automatic logic is_upper(input level_t lv);
    return (lv == LV_HIGH) || (lv == LV_PROG);
  endfunction

endpackage

// File: rtl/tlcd_sync.sv
`timescale 1ns/1ps
module tlcd_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/tlcd_classify.sv
`timescale 1ns/1ps
module tlcd_classify
  import tlcd_pkg::*;
(
  input  logic   lo_i,
  input  logic   hi_i,
  input  logic   pr_i,
  output level_t lv_o
);

  always_comb lv_o = pick_level(lo_i, hi_i, pr_i);

endmodule

// File: rtl/tlcd_qualifier.sv
`timescale 1ns/1ps
module tlcd_qualifier
  import tlcd_pkg::*;
#(
  parameter int unsigned ACC_CYC  = 1000,
  parameter int unsigned GAP_CYC  = 100,
  parameter int unsigned PROG_CYC = 2000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  level_t lv_i,
  input  logic   en_i,
  output logic   inc_o,
  output logic   dec_o,
  output logic   prog_o
);

  localparam int unsigned TOP = (ACC_CYC > PROG_CYC) ? ACC_CYC : PROG_CYC;
  localparam int unsigned CW  = $clog2(TOP + 2);
  localparam logic [CW-1:0] ACC_L  = CW'(ACC_CYC);
  localparam logic [CW-1:0] GAP_L  = CW'(GAP_CYC);
  localparam logic [CW-1:0] PROG_L = CW'(PROG_CYC);
  localparam logic [CW-1:0] PSAT_L = CW'(PROG_CYC + 1);

  level_t        st_q;           // LV_MID when idle, else excursion direction
  logic [CW-1:0] w_cnt, m_cnt, p_cnt;
  logic          gap_ok_q, void_q, prog_seen_q, first_pend_q;

  // named events
  logic in_exc, exc_start, exc_end, dir_flip, width_ok;
  logic exc_qual, count_ok, first_drop, count_go, fire_prog;

  always_comb begin
    in_exc     = (st_q != LV_MID);
    exc_start  = !in_exc && (lv_i != LV_MID);
    exc_end    = in_exc && (lv_i == LV_MID);
    dir_flip   = ((st_q == LV_LOW) && is_upper(lv_i)) ||
                 ((st_q == LV_HIGH) && (lv_i == LV_LOW));
    width_ok   = (w_cnt >= ACC_L);
    exc_qual   = exc_end && width_ok && gap_ok_q && !void_q && !prog_seen_q;
    count_ok   = exc_qual && en_i;
    first_drop = count_ok && first_pend_q;
    count_go   = count_ok && !first_pend_q;
    fire_prog  = (lv_i == LV_PROG) && (p_cnt == PROG_L) && en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= LV_MID;
      w_cnt        <= '0;
      m_cnt        <= '0;
      p_cnt        <= '0;
      gap_ok_q     <= 1'b0;
      void_q       <= 1'b0;
      prog_seen_q  <= 1'b0;
      first_pend_q <= 1'b1;
    end else begin
      if (exc_start) begin
        st_q        <= (lv_i == LV_LOW) ? LV_LOW : LV_HIGH;
        w_cnt       <= CW'(1);
        gap_ok_q    <= (m_cnt >= GAP_L);
        void_q      <= 1'b0;
        prog_seen_q <= (lv_i == LV_PROG);
        p_cnt       <= (lv_i == LV_PROG) ? CW'(1) : '0;
      end else if (exc_end) begin
        st_q  <= LV_MID;
        m_cnt <= CW'(1);
        p_cnt <= '0;
      end else if (in_exc) begin
        if (w_cnt < ACC_L) w_cnt <= w_cnt + 1'b1;
        if (dir_flip) begin
          void_q <= 1'b1;
          st_q   <= (lv_i == LV_LOW) ? LV_LOW : LV_HIGH;
        end
        if (lv_i == LV_PROG) begin
          prog_seen_q <= 1'b1;
          if (p_cnt < PSAT_L) p_cnt <= p_cnt + 1'b1;
        end else begin
          p_cnt <= '0;
        end
      end else begin
        if (m_cnt < GAP_L) m_cnt <= m_cnt + 1'b1;
      end
      if (first_drop) first_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_o  <= 1'b0;
      dec_o  <= 1'b0;
      prog_o <= 1'b0;
    end else begin
      inc_o  <= count_go && (st_q == LV_LOW);
      dec_o  <= count_go && (st_q == LV_HIGH);
      prog_o <= fire_prog;
    end
  end

  // ---------------- assertions ----------------
  assert_inc_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inc_o |=> !inc_o);
  assert_dec_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_o |=> !dec_o);
  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({inc_o, dec_o, prog_o}) <= 1);
  assert_no_strobe_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> !(inc_o || dec_o || prog_o));
  assert_count_after_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_o || dec_o) |-> ($past(lv_i) == LV_MID));
  assert_prog_at_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_o |-> ($past(lv_i) == LV_PROG));
  assert_prog_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_o |=> !prog_o);
  assert_discard_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(first_pend_q));
  assert_count_after_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_o || dec_o) |-> !first_pend_q);
  assert_width_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    w_cnt <= ACC_L);
  assert_hold_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    p_cnt <= PSAT_L);

endmodule

// File: rtl/tri_level_cmd_decoder.sv
`timescale 1ns/1ps
module tri_level_cmd_decoder
  import tlcd_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned QUAL_US     = 100,
  parameter int unsigned GAP_US      = 10,
  parameter int unsigned PROG_US     = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic below_lo_i,
  input  logic above_hi_i,
  input  logic above_prog_i,
  output logic inc_o,
  output logic dec_o,
  output logic prog_req_o
);

  localparam int unsigned ACC_CYC  = us_to_cycles(CLK_HZ, QUAL_US);
  localparam int unsigned GAP_CYC  = us_to_cycles(CLK_HZ, GAP_US);
  localparam int unsigned PROG_CYC = us_to_cycles(CLK_HZ, PROG_US);

  logic [3:0] raw, synced;
  level_t     lv;

  assign raw = {en_i, above_prog_i, above_hi_i, below_lo_i};

  tlcd_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw),
    .q_o   (synced)
  );

  tlcd_classify u_class (
    .lo_i (synced[0]),
    .hi_i (synced[1]),
    .pr_i (synced[2]),
    .lv_o (lv)
  );

  tlcd_qualifier #(
    .ACC_CYC  (ACC_CYC),
    .GAP_CYC  (GAP_CYC),
    .PROG_CYC (PROG_CYC)
  ) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .lv_i   (lv),
    .en_i   (synced[3]),
    .inc_o  (inc_o),
    .dec_o  (dec_o),
    .prog_o (prog_req_o)
  );

endmodule

// File: tb/tri_level_cmd_decoder_tb.sv
`timescale 1ns/1ps
module tri_level_cmd_decoder_tb;

  // 10 MHz scale: 100 us = 1000 cycles, 10 us = 100, 200 us = 2000
  localparam int QUAL = 1000;
  localparam int GAP  = 100;
  localparam int HOLD = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic lo = 1'b0, hi = 1'b0, pr = 1'b0;
  logic inc, dec, prg;

  int n_tests = 0, n_fail = 0;
  int n_inc = 0, n_dec = 0, n_prg = 0, n_multi = 0, n_wide = 0;
  logic prev_inc = 1'b0, prev_dec = 1'b0, prev_prg = 1'b0;

  always #4 clk = ~clk;

  tri_level_cmd_decoder #(.CLK_HZ(10_000_000)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en),
    .below_lo_i(lo), .above_hi_i(hi), .above_prog_i(pr),
    .inc_o(inc), .dec_o(dec), .prog_req_o(prg)
  );

  always @(negedge clk) begin
    if (inc) n_inc++;
    if (dec) n_dec++;
    if (prg) n_prg++;
    if ((inc + dec + prg) > 1) n_multi++;
    if ((inc && prev_inc) || (dec && prev_dec) || (prg && prev_prg)) n_wide++;
    prev_inc = inc; prev_dec = dec; prev_prg = prg;
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  // 0 mid, 1 low, 2 high, 3 programming level (high flag also set)
  task automatic drive(input int lvl, input int cycles);
    @(negedge clk);
    lo = (lvl == 1);
    hi = (lvl >= 2);
    pr = (lvl == 3);
    repeat (cycles - 1) @(negedge clk);
  endtask

  task automatic settle();
    drive(0, 200);
  endtask

  task automatic do_reset();
    en = 1'b1; lo = 0; hi = 0; pr = 0;
    @(negedge clk); rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "strobes during reset release", inc + dec + prg, 0);
    repeat (3) @(negedge clk);
    check("R1", "strobes after reset", inc + dec + prg, 0);
  endtask

  task automatic t_first_discard();
    int i0, d0;
    i0 = n_inc; d0 = n_dec;
    settle(); drive(1, 150); settle();   // short: rejected, keeps discard armed
    check("R4", "sub-20us low ignored", n_inc - i0, 0);
    drive(1, 1500); settle();
    check("R6", "first qualified dropped", n_inc - i0, 0);
    drive(2, 1500); settle();
    check("R3", "high excursion decrements", n_dec - d0, 1);
  endtask

  task automatic t_low();
    int i0;
    i0 = n_inc;
    drive(1, 1200); settle();
    check("R2", "low excursion increments once", n_inc - i0, 1);
  endtask

  task automatic t_width();
    int i0, d0;
    i0 = n_inc; d0 = n_dec;
    drive(1, QUAL - 1); settle();
    check("R4", "999-cycle low rejected", n_inc - i0, 0);
    drive(1, QUAL); settle();
    check("R4", "1000-cycle low accepted", n_inc - i0, 1);
    drive(2, 2500); settle();
    check("R4", "long high accepted", n_dec - d0, 1);
  endtask

  task automatic t_gap();
    int i0;
    i0 = n_inc;
    drive(1, 1200); drive(0, 50); drive(1, 1200); settle();
    check("R5", "50-cycle gap blocks second", n_inc - i0, 1);
    drive(1, 1200); drive(0, GAP - 1); drive(1, 1200); settle();
    check("R5", "99-cycle gap blocks second", n_inc - i0, 2);
    drive(1, 1200); drive(0, GAP); drive(1, 1200); settle();
    check("R5", "100-cycle gap accepted", n_inc - i0, 4);
  endtask

  task automatic t_enable();
    int i0, p0;
    i0 = n_inc; p0 = n_prg;
    en = 1'b0; repeat (5) @(negedge clk);
    drive(1, 1500); settle();
    check("R9", "no increment when disabled", n_inc - i0, 0);
    drive(2, 100); drive(3, 2500); settle();
    check("R9", "no program request when disabled", n_prg - p0, 0);
    en = 1'b1; settle();
    drive(1, 1500); settle();
    check("R9", "counting resumes when enabled", n_inc - i0, 1);
  endtask

  task automatic t_prog();
    int p0, d0;
    p0 = n_prg; d0 = n_dec;
    drive(2, 300); drive(3, HOLD + 1); drive(2, 300); settle();
    check("R7", "hold of 2001 cycles requests", n_prg - p0, 1);
    check("R8", "program hold gives no decrement", n_dec - d0, 0);
    drive(2, 300); drive(3, HOLD); drive(2, 300); settle();
    check("R7", "hold of 2000 cycles no request", n_prg - p0, 1);
    check("R8", "short program hold no decrement", n_dec - d0, 0);
  endtask

  task automatic t_flip();
    int i0, d0;
    i0 = n_inc; d0 = n_dec;
    drive(1, 1200); drive(2, 1200); settle();
    check("R10", "low-to-high reversal silent", (n_inc - i0) + (n_dec - d0), 0);
    drive(2, 1200); drive(1, 1200); settle();
    check("R10", "high-to-low reversal silent", (n_inc - i0) + (n_dec - d0), 0);
  endtask

  task automatic t_priority();
    int i0, d0;
    i0 = n_inc; d0 = n_dec;
    @(negedge clk); lo = 1; hi = 1; pr = 0;
    repeat (1199) @(negedge clk);
    settle();
    check("R12", "low+high flags read as high (dec)", n_dec - d0, 1);
    check("R12", "low+high flags no increment", n_inc - i0, 0);
  endtask

  task automatic t_rearm();
    int i0;
    do_reset(); i0 = n_inc;
    settle(); drive(1, 1500); settle();
    check("R6", "discard re-armed by reset", n_inc - i0, 0);
    drive(1, 1500); settle();
    check("R2", "count after re-armed discard", n_inc - i0, 1);
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL R11 watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_first_discard();
    t_low();
    t_width();
    t_gap();
    t_enable();
    t_prog();
    t_flip();
    t_priority();
    t_rearm();
    check("R11", "cycles with two strobes", n_multi, 0);
    check("R11", "strobes wider than a cycle", n_wide, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule